// File: doc/BRIEF.md
# Single-Wire Slave Addressing Layer

This block is the addressing state machine of a slave on a single-wire open-drain bus. A bit and byte layer below it turns line activity into events: a received command byte, a bit slot with the level sampled in it, and the end of the presence pulse. The block also watches the sampled line level itself and treats a long enough low period as a bus reset. The threshold for that low period depends on the current speed.

After each bus reset and presence pulse, the block expects exactly one addressing command. It can send its 64-bit identifier, compare it against bits the master writes, or take part in a bitwise search. It can also select itself without any identifier exchange. A resume flag lets the master reselect the slave that was last addressed. Two command variants switch the slave to overdrive speed. The memory command layer is enabled only while `mem_sel_o` is high. A slave that fails addressing, or that receives an unknown code, stays silent until the next bus reset.

Top module: `sw_net_layer`

## Requirements
- R1: A low line held for more than the standard threshold (STD_US×CLK_PER_US cycles, so at least threshold+1 consecutive low samples) is a bus reset: selection is dropped and overdrive is cleared. A low period of exactly the threshold has no effect.
- R2: In overdrive, a low period longer than OD_US×CLK_PER_US cycles is a bus reset that keeps overdrive set. At standard speed, a low period of that length has no effect.
- R3: After a bus reset, command bytes are ignored until presence_done_i pulses. The first byte after that pulse is taken as the addressing command.
- R4: Read identifier (code 0x33): the next 64 slots are read slots. In each one the slave drives tx_en_o high and puts identifier bit k on tx_bit_o, least significant bit first. After the 64th slot, mem_sel_o rises.
- R5: Match identifier (code 0x55): the master writes 64 bits, least significant bit first. If all of them equal the identifier, mem_sel_o rises after the 64th slot. On the first mismatch the slave deselects and ignores all bytes and slots until a bus reset.
- R6: Search (code 0xF0) uses three slots per identifier bit. The slave drives the bit, then its complement, then reads the master's chosen bit. A chosen bit that differs from the identifier deselects the slave until a bus reset. Success after 64 triplets raises mem_sel_o.
- R7: Skip (code 0xCC) raises mem_sel_o in the cycle after the byte is taken, and it clears the resume flag.
- R8: Resume (code 0xA5) selects the slave only if the resume flag is set. Only a completed read, match or search sets that flag. Otherwise the slave idles until a bus reset. A failed match or search clears the flag.
- R9: Overdrive skip (code 0x3C) and overdrive match (code 0x69) set od_o in the cycle after the byte is taken. They then behave as skip and as match.
- R10: Any other command code leaves the slave unselected, and it ignores later bytes and slots until a bus reset.
- R11: During reset, od_o, mem_sel_o and tx_en_o are low and tx_bit_o is high. After reset release, the slave ignores commands until the first bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised bus line level |
| presence_done_i | input | 1 | Pulse: presence pulse finished |
| rx_valid_i | input | 1 | Pulse: rx_byte_i holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| slot_i | input | 1 | Pulse: one bit slot completed |
| slot_rx_i | input | 1 | Line level sampled in that slot |
| id_i | input | ID_BITS | Identifier of this slave |
| tx_en_o | output | 1 | Slave drives the coming slot |
| tx_bit_o | output | 1 | Bit for the coming slot (0 pulls low) |
| od_o | output | 1 | Overdrive speed active |
| mem_sel_o | output | 1 | Memory command layer enabled |
| bus_reset_o | output | 1 | One-cycle pulse: bus reset detected |

## Verification
Low pulses are driven at exactly the threshold and one cycle past it, at both speeds. This separates a correct threshold from an off-by-one, and shows which threshold applies in each speed. Identifier exchanges use random identifiers, once with every bit matching and once with one flipped bit at a random position. The full-match runs confirm bit order and completion. The flipped-bit runs show that the slave drops out at the right bit and stays silent afterwards. A seeded random sequence of skip, read, good match, bad match, resume and unknown codes is checked against a bench model of the resume flag. Any mistake in setting or clearing that flag then shows up as a wrong selection after resume.

// File: rtl/sw_net_pkg.sv
package sw_net_pkg;
  typedef enum logic [2:0] {
    NS_IDLE, NS_PRES, NS_CMD, NS_READ, NS_MATCH, NS_SEARCH, NS_MEM
  } net_state_e;

  localparam logic [7:0] CMD_READ_ID  = 8'h33;
  localparam logic [7:0] CMD_MATCH_ID = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_RESUME   = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;
endpackage

// File: rtl/sw_low_timer.sv
module sw_low_timer #(
  parameter int STD_CYC = 120,
  parameter int OD_CYC  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic od_i,
  output logic reset_hit_o,
  output logic std_hit_o
);
  localparam int CW = $clog2(STD_CYC + 2);

  logic [CW-1:0] cnt_q;
  logic          od_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (line_i)                      cnt_q <= '0;
    else if (cnt_q != CW'(STD_CYC + 1))   cnt_q <= cnt_q + 1'b1;
  end

  // Fires on the sample that exceeds the threshold; saturation prevents repeats
  assign std_hit_o   = !line_i && (cnt_q == CW'(STD_CYC));
  assign od_hit      = od_i && !line_i && (cnt_q == CW'(OD_CYC));
  assign reset_hit_o = std_hit_o || od_hit;
endmodule

// File: rtl/sw_id_walk.sv
module sw_id_walk #(
  parameter int ID_BITS = 64,
  localparam int IW = $clog2(ID_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          triple_i,
  output logic [IW-1:0] idx_o,
  output logic [1:0]    phase_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      phase_o <= '0;
    end else if (clr_i) begin
      idx_o   <= '0;
      phase_o <= '0;
    end else if (step_i) begin
      if (triple_i && phase_o != 2'd2) begin
        phase_o <= phase_o + 2'd1;
      end else begin
        phase_o <= '0;
        idx_o   <= idx_o + 1'b1;
      end
    end
  end

  assign last_o = (idx_o == IW'(ID_BITS - 1)) && (!triple_i || phase_o == 2'd2);
endmodule

// File: rtl/sw_net_layer.sv
module sw_net_layer
  import sw_net_pkg::*;
#(
  parameter int ID_BITS    = 64,
  parameter int CLK_PER_US = 1,
  parameter int STD_US     = 120,
  parameter int OD_US      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_i,
  input  logic               presence_done_i,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               slot_i,
  input  logic               slot_rx_i,
  input  logic [ID_BITS-1:0] id_i,
  output logic               tx_en_o,
  output logic               tx_bit_o,
  output logic               od_o,
  output logic               mem_sel_o,
  output logic               bus_reset_o
);
  localparam int STD_CYC = STD_US * CLK_PER_US;
  localparam int OD_CYC  = OD_US * CLK_PER_US;
  localparam int IW      = $clog2(ID_BITS);

  net_state_e    state_q, state_d;
  logic          od_q, od_d, rc_q, rc_d, brst_q;
  logic          reset_hit, std_hit;
  logic [IW-1:0] idx;
  logic [1:0]    phase;
  logic          last, id_bit, walk_clr, walk_step, bit_ok;

  sw_low_timer #(.STD_CYC(STD_CYC), .OD_CYC(OD_CYC)) u_timer (
    .clk_i, .rst_ni, .line_i, .od_i(od_q),
    .reset_hit_o(reset_hit), .std_hit_o(std_hit)
  );

  assign walk_clr  = reset_hit || (state_q == NS_CMD && rx_valid_i);
  assign walk_step = slot_i && (state_q inside {NS_READ, NS_MATCH, NS_SEARCH});

  sw_id_walk #(.ID_BITS(ID_BITS)) u_walk (
    .clk_i, .rst_ni, .clr_i(walk_clr), .step_i(walk_step),
    .triple_i(state_q == NS_SEARCH),
    .idx_o(idx), .phase_o(phase), .last_o(last)
  );

  assign id_bit = id_i[idx];
  assign bit_ok = (slot_rx_i == id_bit);

  always_comb begin
    state_d = state_q;
    od_d    = od_q;
    rc_d    = rc_q;
    if (reset_hit) begin
      state_d = NS_PRES;
      if (std_hit) od_d = 1'b0;
    end else begin
      case (state_q)
        NS_PRES: if (presence_done_i) state_d = NS_CMD;
        NS_CMD: if (rx_valid_i) begin
          rc_d = 1'b0;
          case (rx_byte_i)
            CMD_READ_ID:  state_d = NS_READ;
            CMD_MATCH_ID: state_d = NS_MATCH;
            CMD_SEARCH:   state_d = NS_SEARCH;
            CMD_SKIP:     state_d = NS_MEM;
            CMD_OD_SKIP:  begin state_d = NS_MEM;   od_d = 1'b1; end
            CMD_OD_MATCH: begin state_d = NS_MATCH; od_d = 1'b1; end
            CMD_RESUME:   begin
              state_d = rc_q ? NS_MEM : NS_IDLE;
              rc_d    = rc_q;
            end
            default:      begin state_d = NS_IDLE; rc_d = rc_q; end
          endcase
        end
        NS_READ: if (slot_i && last) begin
          state_d = NS_MEM;
          rc_d    = 1'b1;
        end
        NS_MATCH, NS_SEARCH: if (slot_i && (state_q == NS_MATCH || phase == 2'd2)) begin
          if (!bit_ok)   state_d = NS_IDLE;
          else if (last) begin
            state_d = NS_MEM;
            rc_d    = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= NS_IDLE;
      od_q    <= 1'b0;
      rc_q    <= 1'b0;
      brst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      od_q    <= od_d;
      rc_q    <= rc_d;
      brst_q  <= reset_hit;
    end
  end

  assign tx_en_o     = (state_q == NS_READ) || (state_q == NS_SEARCH && phase != 2'd2);
  assign tx_bit_o    = !tx_en_o || ((state_q == NS_SEARCH && phase == 2'd1) ? !id_bit : id_bit);
  assign od_o        = od_q;
  assign mem_sel_o   = (state_q == NS_MEM);
  assign bus_reset_o = brst_q;
endmodule

// File: rtl/sw_net_layer_chk.sv
module sw_net_layer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic rx_valid_i,
  input logic slot_i,
  input logic tx_en_o,
  input logic od_o,
  input logic mem_sel_o,
  input logic bus_reset_o
);
  // R1
  reset_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> $past(!line_i));

  // R1
  od_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(od_o) |-> bus_reset_o);

  // R9
  od_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(od_o) |-> $past(rx_valid_i));

  // R7
  sel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_sel_o) |-> $past(rx_valid_i || slot_i));

  // R11
  reset_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> (!mem_sel_o && !tx_en_o));

  // R4
  drive_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> !mem_sel_o);
endmodule

bind sw_net_layer sw_net_layer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .rx_valid_i(rx_valid_i),
  .slot_i(slot_i), .tx_en_o(tx_en_o), .od_o(od_o), .mem_sel_o(mem_sel_o),
  .bus_reset_o(bus_reset_o)
);

// File: tb/sw_net_layer_tb.sv
module sw_net_layer_tb;
  import sw_net_pkg::*;
  localparam int STD_CYC = 120;
  localparam int OD_CYC  = 16;

  logic clk = 1'b0, rst_ni = 1'b0, line = 1'b1, pres = 1'b0, rxv = 1'b0;
  logic [7:0] rxb = '0;
  logic slot = 1'b0, srx = 1'b0;
  logic [63:0] id = '0;
  logic tx_en, tx_bit, od, sel, brst;
  int checks = 0, errors = 0;
  bit rc_model = 1'b0;

  always #5 clk = ~clk;

  sw_net_layer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .presence_done_i(pres),
    .rx_valid_i(rxv), .rx_byte_i(rxb), .slot_i(slot), .slot_rx_i(srx), .id_i(id),
    .tx_en_o(tx_en), .tx_bit_o(tx_bit), .od_o(od), .mem_sel_o(sel), .bus_reset_o(brst)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic low(input int n);
    @(negedge clk) line = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk) line = 1'b1;
  endtask

  task automatic presence();
    @(negedge clk) pres = 1'b1;
    @(negedge clk) pres = 1'b0;
  endtask

  task automatic bus_rst();
    low(STD_CYC + 4);
    presence();
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rxv = 1'b1; rxb = b; end
    @(negedge clk) rxv = 1'b0;
  endtask

  task automatic wslot(input logic b);
    @(negedge clk) begin slot = 1'b1; srx = b; end
    @(negedge clk) slot = 1'b0;
  endtask

  task automatic rslot(output logic en, output logic bt);
    @(negedge clk) begin en = tx_en; bt = tx_bit; slot = 1'b1; srx = tx_bit; end
    @(negedge clk) slot = 1'b0;
  endtask

  // flip < 0 sends the identifier unchanged
  task automatic do_match(input int flip, output bit quiet);
    quiet = 1'b1;
    for (int i = 0; i < 64; i++) begin
      wslot((i == flip) ? !id[i] : id[i]);
      if (flip >= 0 && i > flip && tx_en) quiet = 1'b0;
    end
  endtask

  task automatic do_read(output logic [63:0] got, output bit all_en);
    logic en, bt;
    all_en = 1'b1;
    for (int i = 0; i < 64; i++) begin
      rslot(en, bt);
      got[i] = bt;
      if (!en) all_en = 1'b0;
    end
  endtask

  task automatic do_search(input int flip, output bit ok_tx, output bit quiet);
    logic a, b, ea, eb;
    ok_tx = 1'b1; quiet = 1'b1;
    for (int i = 0; i < 64; i++) begin
      rslot(ea, a);
      rslot(eb, b);
      if (flip < 0 || i <= flip) begin
        if (!ea || !eb || a !== id[i] || b !== !id[i]) ok_tx = 1'b0;
      end else if (ea || eb) quiet = 1'b0;
      wslot((i == flip) ? !id[i] : id[i]);
    end
  endtask

  function automatic logic [63:0] rand_id();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] got;
    bit flag_a, flag_b;
    int pos, kind;
    void'($urandom(32'd4242));
    id = rand_id();
    #1;
    // R11 reset state
    chk("R11 od", od, 0); chk("R11 sel", sel, 0);
    chk("R11 tx_en", tx_en, 0); chk("R11 tx_bit", tx_bit, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    send(CMD_SKIP);
    chk("R11 cmd before first bus reset", sel, 0);

    // R3 bytes before presence ignored
    low(STD_CYC + 4);
    send(CMD_SKIP);
    chk("R3 byte before presence", sel, 0);
    presence();
    send(CMD_SKIP);
    chk("R7 skip selects", sel, 1);

    // R1 threshold
    low(STD_CYC);
    chk("R1 low at threshold keeps selection", sel, 1);
    low(STD_CYC + 1);
    chk("R1 low past threshold resets", sel, 0);

    // R2 short pulse at standard speed
    presence();
    send(CMD_SKIP);
    low(OD_CYC + 4);
    chk("R2 od-length low at standard speed", sel, 1);

    // R9 overdrive skip, R2 overdrive reset
    bus_rst();
    send(CMD_OD_SKIP);
    chk("R9 od skip sets od", od, 1);
    chk("R9 od skip selects", sel, 1);
    low(OD_CYC);
    chk("R2 low at od threshold", sel, 1);
    low(OD_CYC + 1);
    chk("R2 od reset deselects", sel, 0);
    chk("R2 od reset keeps od", od, 1);
    presence();
    send(CMD_SKIP);
    chk("R7 skip at overdrive", sel, 1);
    bus_rst();
    chk("R1 standard reset clears od", od, 0);

    // R4 read identifier
    for (int t = 0; t < 3; t++) begin
      id = rand_id();
      bus_rst();
      send(CMD_READ_ID);
      do_read(got, flag_a);
      chk("R4 read bits", got, id);
      chk("R4 read drives", flag_a, 1);
      chk("R4 read selects", sel, 1);
    end

    // R8 resume after read, then after skip
    bus_rst(); send(CMD_RESUME);
    chk("R8 resume after read", sel, 1);
    bus_rst(); send(CMD_SKIP);
    bus_rst(); send(CMD_RESUME);
    chk("R8 resume after skip", sel, 0);
    send(CMD_SKIP);
    chk("R8 failed resume idles", sel, 0);

    // R5 match success and failure
    id = rand_id();
    bus_rst(); send(CMD_MATCH_ID);
    do_match(-1, flag_a);
    chk("R5 match selects", sel, 1);
    pos = int'($urandom % 64);
    bus_rst(); send(CMD_MATCH_ID);
    do_match(pos, flag_a);
    chk("R5 mismatch deselects", sel, 0);
    chk("R5 mismatch silent", flag_a, 1);
    send(CMD_SKIP);
    chk("R5 bytes ignored after mismatch", sel, 0);
    bus_rst(); send(CMD_RESUME);
    chk("R8 resume after failed match", sel, 0);

    // R6 search success and failure
    id = rand_id();
    bus_rst(); send(CMD_SEARCH);
    do_search(-1, flag_a, flag_b);
    chk("R6 search triplets", flag_a, 1);
    chk("R6 search selects", sel, 1);
    bus_rst(); send(CMD_RESUME);
    chk("R8 resume after search", sel, 1);
    pos = int'($urandom % 63);
    bus_rst(); send(CMD_SEARCH);
    do_search(pos, flag_a, flag_b);
    chk("R6 search before drop", flag_a, 1);
    chk("R6 silent after drop", flag_b, 1);
    chk("R6 drop deselects", sel, 0);

    // R9 overdrive match
    bus_rst(); send(CMD_OD_MATCH);
    chk("R9 od match sets od", od, 1);
    chk("R9 od match not yet selected", sel, 0);
    do_match(-1, flag_a);
    chk("R9 od match selects", sel, 1);
    bus_rst();

    // R10 unknown code
    send(8'h00);
    chk("R10 unknown code", sel, 0);
    send(CMD_SKIP);
    chk("R10 bytes ignored", sel, 0);
    wslot(1'b0);
    chk("R10 slots ignored", tx_en, 0);

    // R8 random mix against resume-flag model
    rc_model = 1'b0;
    bus_rst(); send(CMD_SKIP);
    for (int k = 0; k < 30; k++) begin
      kind = int'($urandom % 6);
      id = rand_id();
      bus_rst();
      case (kind)
        0: begin send(CMD_SKIP); rc_model = 0; chk("R7 random skip", sel, 1); end
        1: begin send(CMD_READ_ID); do_read(got, flag_a); rc_model = 1;
                 chk("R4 random read", got, id); end
        2: begin send(CMD_MATCH_ID); do_match(-1, flag_a); rc_model = 1;
                 chk("R5 random match", sel, 1); end
        3: begin send(CMD_MATCH_ID); do_match(int'($urandom % 64), flag_a); rc_model = 0;
                 chk("R5 random bad match", sel, 0); end
        4: begin send(CMD_RESUME); chk("R8 random resume", sel, rc_model); end
        default: begin send(8'h7E); chk("R10 random unknown", sel, 0); end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule